// File: doc/BRIEF.md
# SPI Slave-Select Management Unit

This unit sits in front of an SPI shift engine and decides the internal slave-select level the engine sees. That level comes either from the external select pin or from a bit that software writes. The pin passes through a two-stage synchronizer before use. When software supplies the level, the unit tells the rest of the chip that the pin is free for other uses.

The unit also polices the protocol around that select level. It watches the master/slave mode and the clock-phase setting. It flags a mode fault when a master sees itself deselected-low. It flags a write collision when a slave in phase-0 mode loads its shift register after a byte has finished but before the select has been released. A colliding write is discarded, which shows up as a low accept output in the same cycle. Both flags are sticky and have their own clear strobes.

Slave tracking uses a three-state machine, `sel_state_t`:

- SEL_IDLE means the select is high.
- SEL_ACTIVE means the select is low and writes are allowed.
- SEL_ARMED means a byte has finished while the select was low in strict mode (slave, phase 0), and a deselect is awaited.

The transitions are:

- IDLE to ACTIVE when the select falls.
- IDLE to ARMED when the select falls together with a strict-mode byte end.
- ACTIVE to IDLE when the select rises.
- ACTIVE to ARMED on a strict-mode byte end with the select low.
- ARMED to IDLE when the select rises, which is the release that clears the arming.
- ARMED to ACTIVE when strict mode is left while the select stays low.

Top module: `spi_sel_ctrl`

## Requirements
- R1: During and right after reset, ss_int_o is 1 (the synchronizer stages reset to 1), and wcol_o and modf_o are 0.
- R2: With sw_manage_i=0, ss_int_o equals the value ss_pin_i had two rising clock edges earlier.
- R3: With sw_manage_i=1, ss_int_o equals sw_level_i in the same cycle, whatever ss_pin_i does.
- R4: pin_free_o is 1 exactly when sw_manage_i is 1.
- R5: With master_i=1, a cycle in which ss_int_o is 0 sets modf_o at the next rising edge.
- R6: modf_o stays 1 until a cycle with modf_clr_i=1 and no new fault, after which it is 0. A fault in the same cycle as the clear keeps it 1.
- R7: Strict mode is master_i=0 and cpha_i=0. In strict mode, suppose byte_done_i was seen with ss_int_o low and ss_int_o has stayed low since. A load_i in that state gives load_accept_o=0 in that cycle and sets wcol_o at the next edge.
- R8: In strict mode, a cycle in which ss_int_o is 1 clears the armed state. A later load_i is then accepted, even after the select goes low again.
- R9: With master_i=0 and cpha_i=1, load_i is always accepted, also across byte ends with the select held low, and wcol_o is not set.
- R10: wcol_o stays 1 until a cycle with wcol_clr_i=1 and no new collision, after which it is 0. A collision in the same cycle as the clear keeps it 1.
- R11: In master mode, or while ss_int_o is 1, load_accept_o equals load_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ss_pin_i | input | 1 | External select pin, asynchronous |
| sw_manage_i | input | 1 | 1: software supplies the select level |
| sw_level_i | input | 1 | Software-written select level |
| master_i | input | 1 | 1: master mode, 0: slave mode |
| cpha_i | input | 1 | Clock phase setting |
| load_i | input | 1 | Shift-register write strobe |
| byte_done_i | input | 1 | One-cycle byte-complete pulse |
| wcol_clr_i | input | 1 | Clears the write-collision flag |
| modf_clr_i | input | 1 | Clears the mode-fault flag |
| ss_int_o | output | 1 | Internal select level to the shift engine |
| pin_free_o | output | 1 | Select pin released for general use |
| load_accept_o | output | 1 | Write strobe passed on (0 when discarded) |
| wcol_o | output | 1 | Sticky write-collision flag |
| modf_o | output | 1 | Sticky mode-fault flag |

## Verification
The assertions assume that strobes and byte-end pulses last one cycle and that byte_done_i arrives only while the select is low. They also assume the mode and phase bits are quasi-static around transfers. The stimulus changes every input once per cycle, on the falling clock edge, and raises byte_done_i only inside low-select windows. The asynchronous pin is driven in the same way, so the two-edge lag of the synchronizer is deterministic. That lets the bench test a corner case: a load issued after the pin has risen, but before the rise reaches the internal select, still collides.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

    typedef enum logic [1:0] {
        SEL_IDLE   = 2'd0,
        SEL_ACTIVE = 2'd1,
        SEL_ARMED  = 2'd2
    } sel_state_t;

endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
    parameter int   STAGES      = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RESET_LEVEL;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_LEVEL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_sel_source.sv
module spi_sel_source (
    input  logic pin_sync_i,
    input  logic sw_manage_i,
    input  logic sw_level_i,
    output logic ss_int_o,
    output logic pin_free_o
);
    always_comb begin
        pin_free_o = sw_manage_i;
        ss_int_o   = sw_manage_i ? sw_level_i : pin_sync_i;
    end
endmodule

// File: rtl/spi_sel_fsm.sv
module spi_sel_fsm
    import spi_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ss_int_i,
    input  logic master_i,
    input  logic cpha_i,
    input  logic load_i,
    input  logic byte_done_i,
    output logic load_accept_o,
    output logic collide_o
);
    sel_state_t state_q, state_d;
    logic       strict;

    assign strict = !master_i && !cpha_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE: begin
                if (!ss_int_i) state_d = (byte_done_i && strict) ? SEL_ARMED : SEL_ACTIVE;
            end
            SEL_ACTIVE: begin
                if (ss_int_i)                    state_d = SEL_IDLE;
                else if (byte_done_i && strict)  state_d = SEL_ARMED;
            end
            SEL_ARMED: begin
                if (ss_int_i)     state_d = SEL_IDLE;
                else if (!strict) state_d = SEL_ACTIVE;
            end
            default: state_d = SEL_IDLE;
        endcase
    end

    always_comb begin
        collide_o = 1'b0;
        unique case (state_q)
            SEL_IDLE, SEL_ACTIVE: collide_o = 1'b0;
            SEL_ARMED:            collide_o = load_i && strict && !ss_int_i;
            default:              collide_o = 1'b0;
        endcase
        load_accept_o = load_i && !collide_o;
    end

    // R8: armed only right after a byte end or while already armed
    a_r8_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEL_ARMED) |-> ($past(byte_done_i) || $past(state_q == SEL_ARMED)));
    // R9: relaxed phase or master never discards a write
    a_r9_relaxed_accept: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpha_i || master_i) && load_i) |-> load_accept_o);
    // R11: a deselected unit never discards a write
    a_r11_high_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_int_i && load_i) |-> load_accept_o);
endmodule

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end
endmodule

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_pin_i,
    input  logic sw_manage_i,
    input  logic sw_level_i,
    input  logic master_i,
    input  logic cpha_i,
    input  logic load_i,
    input  logic byte_done_i,
    input  logic wcol_clr_i,
    input  logic modf_clr_i,
    output logic ss_int_o,
    output logic pin_free_o,
    output logic load_accept_o,
    output logic wcol_o,
    output logic modf_o
);
    logic pin_sync;
    logic collide;
    logic fault;

    spi_sel_sync #(.STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ss_pin_i), .q_o(pin_sync)
    );

    spi_sel_source u_source (
        .pin_sync_i(pin_sync), .sw_manage_i(sw_manage_i), .sw_level_i(sw_level_i),
        .ss_int_o(ss_int_o), .pin_free_o(pin_free_o)
    );

    spi_sel_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ss_int_i(ss_int_o), .master_i(master_i),
        .cpha_i(cpha_i), .load_i(load_i), .byte_done_i(byte_done_i),
        .load_accept_o(load_accept_o), .collide_o(collide)
    );

    assign fault = master_i && !ss_int_o;

    spi_sticky_flag u_wcol (
        .clk(clk), .rst_n(rst_n), .set_i(collide), .clr_i(wcol_clr_i), .flag_o(wcol_o)
    );

    spi_sticky_flag u_modf (
        .clk(clk), .rst_n(rst_n), .set_i(fault), .clr_i(modf_clr_i), .flag_o(modf_o)
    );

    // R7: a discarded write raises the collision flag
    a_r7_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !load_accept_o) |=> wcol_o);
    // R10: collision flag holds without a clear
    a_r10_wcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol_o && !wcol_clr_i) |=> wcol_o);
    // R5: master seeing a low select raises mode fault
    a_r5_modf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && !ss_int_o) |=> modf_o);
    // R6: mode fault holds without a clear
    a_r6_modf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (modf_o && !modf_clr_i) |=> modf_o);

    generate
        if (SYNC_STAGES == 2) begin : g_lag_check
            logic [1:0] warm_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              warm_q <= 2'd0;
                else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
            end
            // R2: pin reaches the internal select two edges later
            a_r2_pin_lag: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd3 && !sw_manage_i) |-> (ss_int_o == $past(ss_pin_i, 2)));
        end
    endgenerate
endmodule

// File: tb/test_spi_sel_ctrl.sv
`timescale 1ns/1ps
module test_spi_sel_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ss_pin = 1'b1, ssm = 1'b0, ssi = 1'b1, mstr = 1'b0, cpha = 1'b1;
    logic load = 1'b0, bdone = 1'b0, wclr = 1'b0, mclr = 1'b0;
    logic ss_int, pin_free, accept, wcol, modf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit m_s1 = 1, m_s2 = 1, m_armed = 0, m_wcol = 0, m_modf = 0;

    always #2.5 clk = ~clk;

    spi_sel_ctrl i_spi_sel_ctrl (
        .clk(clk), .rst_n(rst_n), .ss_pin_i(ss_pin), .sw_manage_i(ssm),
        .sw_level_i(ssi), .master_i(mstr), .cpha_i(cpha), .load_i(load),
        .byte_done_i(bdone), .wcol_clr_i(wclr), .modf_clr_i(mclr),
        .ss_int_o(ss_int), .pin_free_o(pin_free), .load_accept_o(accept),
        .wcol_o(wcol), .modf_o(modf)
    );

    function automatic bit model_ss();
        return ssm ? ssi : m_s2;
    endfunction

    function automatic bit model_accept();
        bit strict = !mstr && !cpha;
        return load && !(strict && m_armed && !model_ss());
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_armed = 0; m_wcol = 0; m_modf = 0;
        end else begin
            bit ss_now, strict, acc;
            ss_now = model_ss();
            strict = !mstr && !cpha;
            acc    = model_accept();
            m_wcol  = (load && !acc) || (m_wcol && !wclr);
            m_modf  = (mstr && !ss_now) || (m_modf && !mclr);
            m_armed = strict && !ss_now && (m_armed || bdone);
            m_s2 = m_s1;
            m_s1 = ss_pin;
        end
    end

    task automatic chk(string req, string name, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, name, act, exp, $time);
        end
    endtask

    task automatic compare(string req);
        chk(req, "ss_int", ss_int, model_ss());
        chk("R4", "pin_free", pin_free, ssm);
        chk(req, "load_accept", accept, model_accept());
        chk(req, "wcol", wcol, m_wcol);
        chk(req, "modf", modf, m_modf);
    endtask

    task automatic cyc(string req, bit pin, bit sm, bit sl, bit ms, bit ph,
                       bit ld, bit bd, bit wc, bit mc);
        @(negedge clk);
        ss_pin = pin; ssm = sm; ssi = sl; mstr = ms; cpha = ph;
        load = ld; bdone = bd; wclr = wc; mclr = mc;
        #1;
        compare(req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, pin low during reset must not leak
        ss_pin = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "ss_int", ss_int, 1'b1);
        chk("R1", "wcol", wcol, 1'b0);
        chk("R1", "modf", modf, 1'b0);
        @(negedge clk); rst_n = 1'b1; ss_pin = 1'b1;
        #1;
        chk("R1", "ss_int", ss_int, 1'b1);

        // R2: pin path with two-edge lag, slave phase 1
        cyc("R2", 1,0,1,0,1, 0,0,0,0);
        for (int i = 0; i < 12; i++)
            cyc("R2", (i % 5) < 2, 0,1,0,1, 0,0,0,0);
        cyc("R2", 1,0,1,0,1, 0,0,0,0);
        cyc("R2", 1,0,1,0,1, 0,0,0,0);

        // R3/R4: software level, pin toggles and is ignored
        for (int i = 0; i < 8; i++)
            cyc("R3", i[0], 1, i[1], 0,1, 0,0,0,0);

        // R9: phase 1 slave, select low across byte ends, writes accepted
        cyc("R9", 1,1,0,0,1, 1,0,0,0);
        cyc("R9", 1,1,0,0,1, 0,1,0,0);
        cyc("R9", 1,1,0,0,1, 1,0,0,0);
        cyc("R9", 1,1,0,0,1, 0,1,0,0);
        cyc("R9", 1,1,0,0,1, 1,0,0,0);
        cyc("R9", 1,1,1,0,1, 0,0,0,0);

        // R7: strict mode, byte end then write without deselect
        cyc("R7", 1,1,0,0,0, 1,0,0,0);
        cyc("R7", 1,1,0,0,0, 0,1,0,0);
        cyc("R7", 1,1,0,0,0, 1,0,0,0);
        cyc("R7", 1,1,0,0,0, 0,0,0,0);
        cyc("R7", 1,1,0,0,0, 1,0,0,0);
        // R8: release clears arming; writes accepted after
        cyc("R8", 1,1,1,0,0, 1,0,0,0);
        cyc("R8", 1,1,0,0,0, 1,0,0,0);
        cyc("R8", 1,1,0,0,0, 0,1,0,0);
        // R10: clear together with new collision keeps flag, plain clear drops it
        cyc("R10", 1,1,0,0,0, 1,0,1,0);
        cyc("R10", 1,1,0,0,0, 0,0,0,0);
        cyc("R10", 1,1,1,0,0, 0,0,1,0);
        cyc("R10", 1,1,1,0,0, 0,0,0,0);

        // R8: pin path in strict mode; rise not yet through synchronizer collides
        cyc("R8", 0,0,1,0,0, 0,0,0,0);
        cyc("R8", 0,0,1,0,0, 0,0,0,0);
        cyc("R8", 0,0,1,0,0, 0,0,0,0);
        cyc("R8", 0,0,1,0,0, 0,1,0,0);
        cyc("R8", 1,0,1,0,0, 1,0,0,0);
        cyc("R8", 1,0,1,0,0, 1,0,0,0);
        cyc("R8", 0,0,1,0,0, 1,0,1,0);
        cyc("R8", 0,0,1,0,0, 1,0,0,0);
        cyc("R8", 0,0,1,0,0, 1,0,0,0);
        cyc("R8", 1,0,1,0,0, 0,0,1,0);
        cyc("R8", 1,0,1,0,0, 0,0,0,0);
        cyc("R8", 1,0,1,0,0, 0,0,0,0);

        // R11: master, select high, writes accepted
        cyc("R11", 1,1,1,1,0, 1,0,0,0);
        cyc("R11", 1,1,1,1,1, 1,0,0,0);
        // R5: master sees low select
        cyc("R5", 1,1,0,1,0, 1,0,0,0);
        cyc("R5", 1,1,1,1,0, 0,0,0,0);
        cyc("R5", 1,1,1,1,0, 0,0,0,0);
        // R6: clear with concurrent fault keeps it; plain clear drops it
        cyc("R6", 1,1,0,1,0, 0,0,0,1);
        cyc("R6", 1,1,1,1,0, 0,0,0,0);
        cyc("R6", 1,1,1,1,0, 0,0,0,1);
        cyc("R6", 1,1,1,1,0, 0,0,0,0);
        cyc("R6", 1,1,1,0,1, 0,0,0,0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule